// File: doc/BRIEF.md
# Node Identity Register Bank for a Token-Passing LAN Controller

This block keeps the identity state of one station on a token-passing network and makes it visible to a host over an 8-bit register interface. The host programs the station's own address and a probe address, reads back the address of the station that receives the token next, and sets an interrupt mask and a transmit-enable bit. A 3-bit sub-address chooses the register for each host access.

The bank also gates the protocol core. The core stays asleep while the station address is zero. After a non-zero address is written, the core wakes and the receive path runs. The station takes part in token passing only when the transmit-enable bit is also set.

The protocol sequencer reports each new successor address. Every report sets a new-successor flag, and a host read of the successor register clears that flag. When the receiver sees a station whose address equals the probe address, a probe-hit flag is set. Each flag is ANDed with its mask bit, the results are ORed, and the registered result drives the interrupt output. A software reset clears only the successor register and its flag.

Top module: `node_id_regbank`

## Requirements
- R1: After hardware reset, every mapped register reads 0x00, and `core_awake`, `tx_active` and `irq` are low.
- R2: Sub-address 0 holds the station address, which the host can read and write. `core_awake` is high exactly when the stored station address is non-zero.
- R3: Bit 0 of sub-address 4 is the transmit-enable bit. Reads of sub-address 4 return bits 7..1 as 0. `tx_active` is high only when `core_awake` and transmit-enable are both high.
- R4: `rx_enable` follows `core_awake`, whatever the value of transmit-enable.
- R5: Sub-address 1 holds the probe address, which the host can read and write. The probe-hit flag is bit 1 of sub-address 5. It sets on the clock edge where `rx_src_vld` is high and `rx_src_id` equals the stored probe address. A host write to sub-address 1 clears it. If a set and a clear fall in the same cycle, the set wins.
- R6: Sub-address 2 returns the successor address. `seq_nxt_vld` loads it from `seq_nxt_id`. Host writes to sub-address 2 change nothing.
- R7: The new-successor flag is bit 0 of sub-address 5. Each `seq_nxt_vld` sets it, and a host read of sub-address 2 clears it. When a read and an update fall in the same cycle, the flag stays set.
- R8: `sw_reset` clears the successor address and the new-successor flag. It has priority over an update in the same cycle. It leaves the station address, the probe address, the mask and transmit-enable unchanged.
- R9: Sub-address 3 holds the mask: bit 0 for the new-successor flag, bit 1 for the probe-hit flag, and bits 7..2 read as 0. After each clock edge, `irq` equals the OR of each flag ANDed with its mask bit, using the values written at that edge.
- R10: Reads of sub-addresses 6 and 7 return 0x00. `host_rdata` is 0x00 whenever `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Synchronous software reset pulse |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Register sub-address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| seq_nxt_vld | input | 1 | Sequencer reports a new successor |
| seq_nxt_id | input | 8 | Successor address from the sequencer |
| rx_src_vld | input | 1 | Receiver observed a station |
| rx_src_id | input | 8 | Address of the observed station |
| core_awake | output | 1 | Protocol core may run |
| tx_active | output | 1 | Station may take part in token passing |
| rx_enable | output | 1 | Receive path enabled |
| irq | output | 1 | Registered, masked interrupt |

## Verification
The assertions assume that the host raises at most one of `host_wr` and `host_rd` in any cycle, and that strobes and data are stable around each rising edge. The bench changes every input only on the falling edge, and each call of its stimulus task issues a single operation. The same-cycle overlaps the bank has to resolve come only from the sequencer, receiver and reset inputs meeting a host access: an update meeting a successor read, a software reset meeting an update, and a probe hit meeting a probe write. The stimulus creates each of these overlaps on purpose.

// File: rtl/nid_pkg.sv
package nid_pkg;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int NREG  = 6;
    localparam int NFLAG = 2;

    localparam int FLAG_NXT  = 0;
    localparam int FLAG_TENT = 1;

    typedef enum logic [AW-1:0] {
        SA_NODE = 3'd0,
        SA_TENT = 3'd1,
        SA_NEXT = 3'd2,
        SA_MASK = 3'd3,
        SA_CTRL = 3'd4,
        SA_STAT = 3'd5
    } sub_addr_e;
endpackage

// File: rtl/nid_addr_dec.sv
module nid_addr_dec #(
    parameter int AW   = 3,
    parameter int NREG = 6
) (
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic [AW-1:0]   host_addr,
    output logic [NREG-1:0] wr_hit,
    output logic [NREG-1:0] rd_hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign wr_hit[i] = host_wr && (host_addr == AW'(i));
        assign rd_hit[i] = host_rd && (host_addr == AW'(i));
    end
endmodule

// File: rtl/nid_flag_unit.sv
module nid_flag_unit #(
    parameter int             N      = 2,
    parameter logic [N-1:0]   SW_CLR = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_reset,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_d_i,
    output logic [N-1:0] flag_q_o,
    output logic         irq_q_o
);
    typedef struct packed {
        logic [N-1:0] flag;
        logic         irq;
    } fstate_t;

    fstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set_i[i]) begin
                st_d.flag[i] = 1'b1;
            end else if (clr_i[i]) begin
                st_d.flag[i] = 1'b0;
            end
            if (sw_reset && SW_CLR[i]) begin
                st_d.flag[i] = 1'b0;
            end
        end
        st_d.irq = |(st_d.flag & mask_d_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q_o = st_q.flag;
    assign irq_q_o  = st_q.irq;
endmodule

// File: rtl/node_id_regbank.sv
module node_id_regbank
    import nid_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_reset,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          seq_nxt_vld,
    input  logic [DW-1:0] seq_nxt_id,
    input  logic          rx_src_vld,
    input  logic [DW-1:0] rx_src_id,
    output logic          core_awake,
    output logic          tx_active,
    output logic          rx_enable,
    output logic          irq
);
    localparam logic [NFLAG-1:0] SW_CLR_FLAGS = NFLAG'(1) << FLAG_NXT;

    typedef struct packed {
        logic [DW-1:0]    node_id;
        logic [DW-1:0]    tent_id;
        logic [DW-1:0]    next_id;
        logic [NFLAG-1:0] mask;
        logic             tx_en;
    } regs_t;

    regs_t st_d, st_q;

    logic [NREG-1:0]  wr_hit;
    logic [NREG-1:0]  rd_hit;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flag_q;
    logic [DW-1:0]    next_id_q;
    logic [NFLAG-1:0] mask_q;

    nid_addr_dec #(.AW(AW), .NREG(NREG)) u_dec (
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_hit[SA_NODE]) st_d.node_id = host_wdata;
        if (wr_hit[SA_TENT]) st_d.tent_id = host_wdata;
        if (wr_hit[SA_MASK]) st_d.mask    = host_wdata[NFLAG-1:0];
        if (wr_hit[SA_CTRL]) st_d.tx_en   = host_wdata[0];
        if (sw_reset) begin
            st_d.next_id = '0;
        end else if (seq_nxt_vld) begin
            st_d.next_id = seq_nxt_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flag_set            = '0;
        flag_clr            = '0;
        flag_set[FLAG_NXT]  = seq_nxt_vld;
        flag_clr[FLAG_NXT]  = rd_hit[SA_NEXT];
        flag_set[FLAG_TENT] = rx_src_vld && (rx_src_id == st_q.tent_id);
        flag_clr[FLAG_TENT] = wr_hit[SA_TENT];
    end

    nid_flag_unit #(.N(NFLAG), .SW_CLR(SW_CLR_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_reset (sw_reset),
        .set_i    (flag_set),
        .clr_i    (flag_clr),
        .mask_d_i (st_d.mask),
        .flag_q_o (flag_q),
        .irq_q_o  (irq)
    );

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            unique case (host_addr)
                SA_NODE: host_rdata = st_q.node_id;
                SA_TENT: host_rdata = st_q.tent_id;
                SA_NEXT: host_rdata = st_q.next_id;
                SA_MASK: host_rdata = DW'(st_q.mask);
                SA_CTRL: host_rdata = DW'(st_q.tx_en);
                SA_STAT: host_rdata = DW'(flag_q);
                default: host_rdata = '0;
            endcase
        end
    end

    assign next_id_q  = st_q.next_id;
    assign mask_q     = st_q.mask;
    assign core_awake = |st_q.node_id;
    assign rx_enable  = core_awake;
    assign tx_active  = core_awake && st_q.tx_en;
endmodule

// File: rtl/nid_checker.sv
module nid_checker
    import nid_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sw_reset,
    input logic             host_wr,
    input logic             host_rd,
    input logic [AW-1:0]    host_addr,
    input logic [DW-1:0]    host_wdata,
    input logic [DW-1:0]    host_rdata,
    input logic             seq_nxt_vld,
    input logic             core_awake,
    input logic             tx_active,
    input logic             rx_enable,
    input logic             irq,
    input logic [DW-1:0]    next_id_q,
    input logic [NFLAG-1:0] flag_q,
    input logic [NFLAG-1:0] mask_q
);
    p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == SA_NODE && host_wdata != '0) |=> core_awake);

    p_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == SA_NODE && host_wdata == '0) |=> !core_awake);

    p_tx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> core_awake);

    p_rx_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_awake |-> rx_enable);

    p_ro_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == SA_NEXT && !seq_nxt_vld && !sw_reset) |=> $stable(next_id_q));

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_nxt_vld && !sw_reset) |=> flag_q[FLAG_NXT]);

    p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == SA_NEXT && !seq_nxt_vld) |=> !flag_q[FLAG_NXT]);

    p_swrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (next_id_q == '0 && !flag_q[FLAG_NXT]));

    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> |(flag_q & mask_q));

    p_idle_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd || host_addr > SA_STAT) |-> host_rdata == '0);
endmodule

bind node_id_regbank nid_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_reset    (sw_reset),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .seq_nxt_vld (seq_nxt_vld),
    .core_awake  (core_awake),
    .tx_active   (tx_active),
    .rx_enable   (rx_enable),
    .irq         (irq),
    .next_id_q   (next_id_q),
    .flag_q      (flag_q),
    .mask_q      (mask_q)
);

// File: tb/sim_node_id_regbank.sv
`timescale 1ns/1ps
module sim_node_id_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       seq_nxt_vld = 1'b0;
    logic [7:0] seq_nxt_id = '0;
    logic       rx_src_vld = 1'b0;
    logic [7:0] rx_src_id = '0;
    logic       core_awake, tx_active, rx_enable, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    int m_node, m_tent, m_next, m_mask, m_txen, m_fnxt, m_ftent, m_irq;

    always #2 clk = ~clk;

    node_id_regbank u0 (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .seq_nxt_vld(seq_nxt_vld), .seq_nxt_id(seq_nxt_id),
        .rx_src_vld(rx_src_vld), .rx_src_id(rx_src_id),
        .core_awake(core_awake), .tx_active(tx_active),
        .rx_enable(rx_enable), .irq(irq)
    );

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_rd(int a);
        case (a)
            0: return m_node;
            1: return m_tent;
            2: return m_next;
            3: return m_mask;
            4: return m_txen;
            5: return (m_ftent << 1) | m_fnxt;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_node = 0; m_tent = 0; m_next = 0; m_mask = 0;
        m_txen = 0; m_fnxt = 0; m_ftent = 0; m_irq = 0;
    endtask

    // one cycle: drive at negedge, compare, then advance model at posedge
    task automatic cyc(bit wr, bit rd, int a, int wd,
                       bit sv, int sid, bit rv, int rid, bit swr, string tag);
        int hit;
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_addr = 3'(a); host_wdata = 8'(wd);
        seq_nxt_vld = sv; seq_nxt_id = 8'(sid);
        rx_src_vld = rv; rx_src_id = 8'(rid); sw_reset = swr;
        #1;
        check("R2 core_awake", int'(core_awake), int'(m_node != 0));
        check("R3 tx_active", int'(tx_active), int'(m_node != 0 && m_txen != 0));
        check("R4 rx_enable", int'(rx_enable), int'(m_node != 0));
        check("R9 irq", int'(irq), m_irq);
        check(tag, int'(host_rdata), rd ? exp_rd(a) : 0);
        @(posedge clk);
        hit = int'(rv && rid == m_tent);
        if (hit != 0) m_ftent = 1;
        else if (wr && a == 1) m_ftent = 0;
        if (sv) m_fnxt = 1;
        else if (rd && a == 2) m_fnxt = 0;
        if (swr) begin m_fnxt = 0; m_next = 0; end
        else if (sv) m_next = sid;
        if (wr) begin
            case (a)
                0: m_node = wd;
                1: m_tent = wd;
                3: m_mask = wd & 3;
                4: m_txen = wd & 1;
                default: ;
            endcase
        end
        m_irq = int'(((m_fnxt & m_mask) != 0) || ((m_ftent != 0) && (m_mask & 2) != 0));
    endtask

    task automatic wr_reg(int a, int d, string tag);
        cyc(1, 0, a, d, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic rd_reg(int a, string tag);
        cyc(0, 1, a, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(4 * 5000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset values of every register
        for (int a = 0; a < 6; a++) rd_reg(a, "R1 reset read");
        // R2: zero station address keeps core asleep; R3 tx needs awake
        wr_reg(0, 0, "R2 idle");
        wr_reg(4, 8'hFF, "R3 idle");
        rd_reg(4, "R3 ctrl readback");
        wr_reg(0, 8'h2A, "R2 idle");
        rd_reg(0, "R2 node readback");
        // R4: receive stays on with transmit disabled
        wr_reg(4, 0, "R4 idle");
        rd_reg(4, "R4 ctrl readback");
        // R5: probe address and hit flag
        wr_reg(1, 8'h11, "R5 idle");
        rd_reg(1, "R5 tent readback");
        cyc(0, 0, 0, 0, 0, 0, 1, 8'h12, 0, "R5 idle");
        rd_reg(5, "R5 no hit");
        cyc(0, 0, 0, 0, 0, 0, 1, 8'h11, 0, "R5 idle");
        rd_reg(5, "R5 hit set");
        wr_reg(1, 8'h20, "R5 idle");
        rd_reg(5, "R5 hit cleared");
        cyc(1, 0, 1, 8'h21, 0, 0, 1, 8'h20, 0, "R5 idle");
        rd_reg(5, "R5 set beats clear");
        wr_reg(1, 8'h21, "R5 idle");
        // R6/R7 with interrupts masked
        cyc(0, 0, 0, 0, 1, 8'h33, 0, 0, 0, "R7 idle");
        rd_reg(5, "R7 flag set");
        rd_reg(2, "R6 next value");
        rd_reg(5, "R7 flag cleared by read");
        wr_reg(2, 8'h55, "R6 idle");
        rd_reg(2, "R6 write ignored");
        // R9: mask enables irq
        wr_reg(3, 8'hFF, "R9 idle");
        rd_reg(3, "R9 mask readback");
        cyc(0, 0, 0, 0, 1, 8'h44, 0, 0, 0, "R9 idle");
        cyc(0, 1, 2, 0, 1, 8'h45, 0, 0, 0, "R7 read with update");
        rd_reg(5, "R7 flag held");
        rd_reg(2, "R7 new value kept");
        rd_reg(5, "R7 flag cleared");
        cyc(0, 0, 0, 0, 0, 0, 1, 8'h21, 0, "R9 idle");
        wr_reg(3, 8'h01, "R9 idle");
        wr_reg(1, 8'h21, "R9 idle");
        // R8: software reset beats update, keeps other registers
        cyc(0, 0, 0, 0, 1, 8'h66, 0, 0, 0, "R8 idle");
        cyc(0, 0, 0, 0, 1, 8'h77, 0, 0, 1, "R8 idle");
        rd_reg(2, "R8 next cleared");
        rd_reg(5, "R8 flag cleared");
        rd_reg(0, "R8 node kept");
        rd_reg(1, "R8 tent kept");
        rd_reg(3, "R8 mask kept");
        // R10: unmapped reads
        rd_reg(6, "R10 unmapped 6");
        rd_reg(7, "R10 unmapped 7");
        wr_reg(7, 8'hAA, "R10 idle");
        // R2: back to sleep
        wr_reg(4, 1, "R3 idle");
        wr_reg(0, 0, "R2 idle");
        rd_reg(0, "R2 sleep readback");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule